// File: doc/BRIEF.md
# Edge-Capture Timer Channel

This block is one channel of a general-purpose timer, set up to measure time between events. A counter steps on a chosen count clock. Rising or falling edges of input A copy the count into two capture registers, A-capture and B-capture, so software can measure pulse widths and periods. The count clock comes from one of five internal square waves produced from the system clock or from one of three external clock pins. The clock can be inverted, and it can be ANDed with one of the external pins to form a gated burst.

Three kinds of event restart the count: a software command, an edge on input A or B, and a match between the counter and a compare register. After any of them, the next active count-clock edge loads zero. A B-capture can freeze the counter or turn its clock off. Sticky status flags, with a per-flag interrupt mask, report the events. Software reaches the block through a plain register port. A write or read takes effect at the clock edge on which its enable is high. Read data is combinational from the read address. There is no back-pressure: the port accepts an access on every cycle.

Register addresses: 0 command (write: bit0 start, bit1 halt, bit2 software trigger), 1 mode, 2 count, 3 A-capture, 4 B-capture, 5 compare value, 6 status, 7 mask set, 8 mask clear, 9 mask readback.

Mode fields:
- [2:0] clock source
- [3] invert
- [5:4] gate: 0 none, 1..3 = ext_clk[0..2]
- [7:6] A-capture edge
- [9:8] B-capture edge
- [10] freeze on B-capture
- [11] clock-off on B-capture
- [13:12] trigger edge
- [14] trigger from input B
- [15] compare restart

Every edge field uses the same codes: 0 none, 1 rising, 2 falling, 3 both.

Status and mask bits:
- bit0 overflow
- bit1 capture overrun
- bit2 compare match
- bit3 A-capture loaded
- bit4 B-capture loaded
- bit5 external trigger

The status word also holds three read-only bits: bit8 clock enabled, bit9 input A level, bit10 input B level.

Top module: `capture_timer`

## Requirements
- R1: Clock source codes 0..4 select internal square waves with periods of 2, 8, 32, 128 and 512 system clocks. Codes 5..7 select ext_clk[0..2]. The counter advances by one on each rising edge of the selected source.
- R2: With the invert bit set, the counter advances on the falling edge of the source and not on the rising edge.
- R3: With gate code g nonzero, the source is ANDed with ext_clk[g-1], so no edge counts while that pin is low.
- R4: A-capture and B-capture each load the counter on their own selected edges of input A. The value loaded is the count held when the synchronised edge is seen.
- R5: A B-capture with mode bit 10 set freezes counting until the next trigger. A B-capture with mode bit 11 set clears the clock-enabled state.
- R6: A software trigger (command bit2) leaves the count unchanged until the next active count edge, which loads zero.
- R7: An edge on input A, or on input B when mode bit 14 is set, that matches the trigger edge field raises status bit5 and restarts the count like R6.
- R8: When an advance brings the counter equal to the compare value, status bit2 is raised. If mode bit 15 is set, that match also restarts the count.
- R9: Loading a capture register whose previous value has not been read raises status bit1. A read of that register prevents this.
- R10: After reset the clock is off and the count is 0. Command bit0 enables the clock and command bit1 disables it, and bit1 wins when both are written. While the clock is off the count holds.
- R11: When the counter advances from its all-ones value it wraps to 0 and raises status bit0.
- R12: Reading status clears bits 5:0, with a new event winning over the clear. Bits 9 and 10 mirror inputs A and B. irq is high exactly when some flag and its mask bit are both set. Mask set and mask clear writes change only the bits written as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe; side effects occur at the clock edge |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data for rd_addr |
| in_a | input | 1 | Capture and trigger input A (asynchronous) |
| in_b | input | 1 | Trigger input B (asynchronous) |
| ext_clk | input | 3 | External clock and gate pins (asynchronous) |
| irq | output | 1 | Masked OR of status flags |

## Verification
The assertions take for granted that the pins change slowly compared with the system clock. They also assume that software changes the clock source, the invert bit or the gate only while the selected level is low or the clock is off, because a change at any other time can produce one extra edge. The stimulus holds every pin pulse for four system clocks and returns the pulsed external clock low before it rewrites the mode. It halts the clock around inversion changes and restarts the count with a software trigger before each measured sequence.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int N_FLAG = 6;

  localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAPA  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAPB  = 4'd4;
  localparam logic [ADDR_W-1:0] A_RCMP  = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd7;
  localparam logic [ADDR_W-1:0] A_IDIS  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IMASK = 4'd9;

  localparam int F_OVF = 0;
  localparam int F_OVR = 1;
  localparam int F_RC  = 2;
  localparam int F_LDA = 3;
  localparam int F_LDB = 4;
  localparam int F_TRG = 5;

  typedef struct packed {
    logic       rc_trig;
    logic       trig_src_b;
    logic [1:0] trig_edge;
    logic       dis_on_b;
    logic       stop_on_b;
    logic [1:0] capb_edge;
    logic [1:0] capa_edge;
    logic [1:0] gate;
    logic       inv;
    logic [2:0] clksel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic edge_hit(logic [1:0] sel, logic rise, logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/ctmr_sync.sv
module ctmr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign lvl[i]  = s2_q;
    assign rise[i] = s2_q & ~prev_q;
    assign fall[i] = ~s2_q & prev_q;
  end
endmodule

// File: rtl/ctmr_clk_sel.sv
module ctmr_clk_sel #(
  parameter int SEL_W    = 3,
  parameter int N_EXT    = 3,
  parameter int DIV_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clksel,
  input  logic             inv,
  input  logic [1:0]       gate,
  input  logic [N_EXT-1:0] ext_lvl,
  output logic             tick
);
  localparam int N_SRC = 1 << SEL_W;
  localparam int N_INT = N_SRC - N_EXT;
  localparam int DIV_W = (N_INT - 1) * DIV_STEP + 1;

  logic [DIV_W-1:0] div_q;
  logic [N_INT-1:0] int_lvl;
  logic [N_SRC-1:0] all_lvl;
  logic [3:0]       gate_lvl;
  logic             lvl, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < N_INT; k++) begin : g_int
    assign int_lvl[k] = div_q[k*DIV_STEP];
  end

  assign all_lvl  = {ext_lvl, int_lvl};
  assign gate_lvl = {ext_lvl[2:0], 1'b1};
  assign lvl      = (all_lvl[clksel] & gate_lvl[gate]) ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign tick = lvl & ~lvl_q;
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  mode_t             mode,
  input  logic [CNT_W-1:0]  rc_val,
  input  logic              cmd_start,
  input  logic              cmd_halt,
  input  logic              cmd_swtrg,
  input  logic              a_rise,
  input  logic              a_fall,
  input  logic              b_rise,
  input  logic              b_fall,
  input  logic              rd_capa,
  input  logic              rd_capb,
  input  logic              rd_status,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  capa,
  output logic [CNT_W-1:0]  capb,
  output logic              clk_on,
  output logic [N_FLAG-1:0] flags,
  output logic              trig_pend,
  output logic              rc_hit,
  output logic              capa_ld,
  output logic              capb_ld,
  output logic              unread_a
);
  logic             stopped_q, upd_q, unread_b_q;
  logic             ext_trig, any_trig, step, ovf;
  logic [N_FLAG-1:0] set_f;

  assign ext_trig = mode.trig_src_b ? edge_hit(mode.trig_edge, b_rise, b_fall)
                                    : edge_hit(mode.trig_edge, a_rise, a_fall);
  assign capa_ld  = edge_hit(mode.capa_edge, a_rise, a_fall);
  assign capb_ld  = edge_hit(mode.capb_edge, a_rise, a_fall);
  assign rc_hit   = upd_q && (cnt == rc_val);
  assign any_trig = cmd_swtrg | ext_trig | (mode.rc_trig & rc_hit);
  assign step     = tick & clk_on & ~stopped_q;
  assign ovf      = step & ~trig_pend & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= step;
      if (step) cnt <= trig_pend ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_pend <= 1'b0;
      stopped_q <= 1'b0;
      clk_on    <= 1'b0;
    end else begin
      if (any_trig)  trig_pend <= 1'b1;
      else if (step) trig_pend <= 1'b0;
      if (any_trig)                        stopped_q <= 1'b0;
      else if (capb_ld && mode.stop_on_b)  stopped_q <= 1'b1;
      if (cmd_halt || (capb_ld && mode.dis_on_b)) clk_on <= 1'b0;
      else if (cmd_start)                         clk_on <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capa       <= '0;
      capb       <= '0;
      unread_a   <= 1'b0;
      unread_b_q <= 1'b0;
    end else begin
      if (capa_ld) begin
        capa     <= cnt;
        unread_a <= 1'b1;
      end else if (rd_capa) begin
        unread_a <= 1'b0;
      end
      if (capb_ld) begin
        capb       <= cnt;
        unread_b_q <= 1'b1;
      end else if (rd_capb) begin
        unread_b_q <= 1'b0;
      end
    end
  end

  always_comb begin
    set_f        = '0;
    set_f[F_OVF] = ovf;
    set_f[F_OVR] = (capa_ld & unread_a) | (capb_ld & unread_b_q);
    set_f[F_RC]  = rc_hit;
    set_f[F_LDA] = capa_ld;
    set_f[F_LDB] = capb_ld;
    set_f[F_TRG] = ext_trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_status ? '0 : flags) | set_f;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ctmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              in_a,
  input  logic              in_b,
  input  logic [2:0]        ext_clk,
  output logic              irq
);
  localparam int N_PIN = 5;

  mode_t             mode_q;
  logic [CNT_W-1:0]  rc_q;
  logic [N_FLAG-1:0] mask_q;
  logic [N_PIN-1:0]  pin_lvl, pin_rise, pin_fall;
  logic              tick;
  logic              wr_cmd;
  logic [CNT_W-1:0]  cnt, capa, capb;
  logic              clk_on, trig_pend, rc_hit, capa_ld, capb_ld, unread_a;
  logic [N_FLAG-1:0] flags;

  assign wr_cmd = wr_en && (wr_addr == A_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rc_q   <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode_q <= mode_t'(wr_data[MODE_W-1:0]);
        A_RCMP: rc_q   <= wr_data[CNT_W-1:0];
        A_IEN:  mask_q <= mask_q | wr_data[N_FLAG-1:0];
        A_IDIS: mask_q <= mask_q & ~wr_data[N_FLAG-1:0];
        default: ;
      endcase
    end
  end

  ctmr_sync #(.W(N_PIN)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({ext_clk, in_b, in_a}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  ctmr_clk_sel #(.SEL_W(3), .N_EXT(3), .DIV_STEP(DIV_STEP)) clk_sel_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clksel (mode_q.clksel),
    .inv    (mode_q.inv),
    .gate   (mode_q.gate),
    .ext_lvl(pin_lvl[4:2]),
    .tick   (tick)
  );

  ctmr_core #(.CNT_W(CNT_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode_q),
    .rc_val   (rc_q),
    .cmd_start(wr_cmd & wr_data[0]),
    .cmd_halt (wr_cmd & wr_data[1]),
    .cmd_swtrg(wr_cmd & wr_data[2]),
    .a_rise   (pin_rise[0]),
    .a_fall   (pin_fall[0]),
    .b_rise   (pin_rise[1]),
    .b_fall   (pin_fall[1]),
    .rd_capa  (rd_en && (rd_addr == A_CAPA)),
    .rd_capb  (rd_en && (rd_addr == A_CAPB)),
    .rd_status(rd_en && (rd_addr == A_STAT)),
    .cnt      (cnt),
    .capa     (capa),
    .capb     (capb),
    .clk_on   (clk_on),
    .flags    (flags),
    .trig_pend(trig_pend),
    .rc_hit   (rc_hit),
    .capa_ld  (capa_ld),
    .capb_ld  (capb_ld),
    .unread_a (unread_a)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE:  rd_data = DATA_W'(mode_q);
      A_COUNT: rd_data = DATA_W'(cnt);
      A_CAPA:  rd_data = DATA_W'(capa);
      A_CAPB:  rd_data = DATA_W'(capb);
      A_RCMP:  rd_data = DATA_W'(rc_q);
      A_STAT:  rd_data = DATA_W'({pin_lvl[1], pin_lvl[0], clk_on, 2'b00, flags});
      A_IMASK: rd_data = DATA_W'(mask_q);
      default: rd_data = '0;
    endcase
  end

  assign irq = |(flags & mask_q);
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input mode_t             mode_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              clk_on,
  input logic              trig_pend,
  input logic              rc_hit,
  input logic              capa_ld,
  input logic              capb_ld,
  input logic              unread_a,
  input logic [N_FLAG-1:0] flags
);
  assert_halt_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CMD && wr_data[1]) |=> !clk_on);

  assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> $stable(cnt));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  assert_rc_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && mode_q.rc_trig) |=> trig_pend);

  assert_off_on_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capb_ld && mode_q.dis_on_b) |=> !clk_on);

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (capa_ld && unread_a) |=> flags[F_OVR]);
endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .mode_q   (mode_q),
  .cnt      (cnt),
  .clk_on   (clk_on),
  .trig_pend(trig_pend),
  .rc_hit   (rc_hit),
  .capa_ld  (capa_ld),
  .capb_ld  (capb_ld),
  .unread_a (unread_a),
  .flags    (flags)
);

// File: tb/capture_timer_tb_top.sv
module capture_timer_tb_top;
  import ctmr_pkg::*;

  localparam int CNT_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              in_a = 1'b0;
  logic              in_b = 1'b0;
  logic [2:0]        ext_clk = '0;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  capture_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .in_a(in_a), .in_b(in_b), .ext_clk(ext_clk), .irq(irq)
  );

  function automatic logic [31:0] mk_mode(int sel, int inv, int gate, int ea, int eb,
                                          int stp, int dis, int te, int tsb, int rct);
    return 32'((sel & 7) | ((inv & 1) << 3) | ((gate & 3) << 4) | ((ea & 3) << 6) |
               ((eb & 3) << 8) | ((stp & 1) << 10) | ((dis & 1) << 11) |
               ((te & 3) << 12) | ((tsb & 1) << 14) | ((rct & 1) << 15));
  endfunction

  function automatic logic [31:0] wrap(int v);
    return 32'(v % (1 << CNT_W));
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    cyc(1);
    rd_en = 1'b0;
  endtask

  task automatic pulse(int n, int which = 0);
    for (int i = 0; i < n; i++) begin
      ext_clk[which] = 1'b1; cyc(4);
      ext_clk[which] = 1'b0; cyc(4);
    end
  endtask

  task automatic set_a(logic v);
    in_a = v; cyc(5);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_cnt(string req, int exp);
    logic [31:0] v;
    rd(A_COUNT, v);
    check(req, v, wrap(exp));
  endtask

  task automatic restart();
    logic [31:0] v;
    wr(A_CMD, 32'h4);
    pulse(1);
    rd(A_STAT, v);
  endtask

  initial begin
    logic [31:0] v, c0, c1;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // reset state
    check_cnt("R10 reset count", 0);
    rd(A_STAT, v); check("R12 reset status", v, 32'h0);
    check("R12 reset irq", 32'(irq), 32'h0);

    // clock off: count holds
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    pulse(3);
    check_cnt("R10 halted holds", 0);
    wr(A_CMD, 32'h1);
    rd(A_STAT, v); check("R10 clock enabled bit", v & 32'h100, 32'h100);
    pulse(5);
    check_cnt("R1 ext_clk0 counts", 5);

    // source code 6 ignores ext_clk[0]
    wr(A_MODE, mk_mode(6, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    pulse(3, 0);
    check_cnt("R1 unselected pin ignored", 5);
    pulse(2, 1);
    check_cnt("R1 ext_clk1 counts", 7);

    // internal sources
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    cyc(2); rd(A_COUNT, c0); cyc(99); rd(A_COUNT, c1);
    check("R1 source 0 rate", 32'((wrap(int'(c1) - int'(c0) + 256) >= 49) &&
                                  (wrap(int'(c1) - int'(c0) + 256) <= 51)), 32'h1);
    wr(A_MODE, mk_mode(4, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    cyc(2); rd(A_COUNT, c0); cyc(1099); rd(A_COUNT, c1);
    check("R1 source 4 rate", 32'((wrap(int'(c1) - int'(c0) + 256) >= 2) &&
                                  (wrap(int'(c1) - int'(c0) + 256) <= 3)), 32'h1);

    // software trigger
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    restart();
    pulse(9);
    check_cnt("R6 before trigger", 9);
    wr(A_CMD, 32'h4);
    check_cnt("R6 held until next edge", 9);
    pulse(1);
    check_cnt("R6 zero on next edge", 0);
    pulse(4);
    check_cnt("R6 counts after restart", 4);

    // invert
    wr(A_CMD, 32'h2);
    wr(A_MODE, mk_mode(5, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    cyc(3);
    wr(A_CMD, 32'h1);
    ext_clk[0] = 1'b1; cyc(5);
    check_cnt("R2 rising edge ignored", 4);
    ext_clk[0] = 1'b0; cyc(5);
    check_cnt("R2 falling edge counts", 5);
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));

    // gate
    wr(A_MODE, mk_mode(5, 0, 3, 0, 0, 0, 0, 0, 0, 0));
    pulse(4);
    check_cnt("R3 gated off", 5);
    ext_clk[2] = 1'b1; cyc(4);
    pulse(3);
    check_cnt("R3 gate open", 8);
    ext_clk[2] = 1'b0; cyc(4);

    // captures: A rising, B falling
    wr(A_MODE, mk_mode(5, 0, 0, 1, 2, 0, 0, 0, 0, 0));
    restart();
    pulse(7); set_a(1'b1); pulse(5); set_a(1'b0);
    rd(A_CAPA, v); check("R4 A-capture on rise", v, 32'd7);
    rd(A_CAPB, v); check("R4 B-capture on fall", v, 32'd12);
    rd(A_STAT, v); check("R4 load flags", v & 32'h18, 32'h18);
    wr(A_MODE, mk_mode(5, 0, 0, 3, 0, 0, 0, 0, 0, 0));
    restart();
    pulse(2); set_a(1'b1);
    rd(A_CAPA, v); check("R4 both-edge rise", v, 32'd2);
    pulse(3); set_a(1'b0);
    rd(A_CAPA, v); check("R4 both-edge fall", v, 32'd5);

    // mirrors
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    set_a(1'b1);
    rd(A_STAT, v); check("R12 mirror A high B low", v & 32'h600, 32'h200);
    set_a(1'b0);

    // freeze on B-capture
    wr(A_MODE, mk_mode(5, 0, 0, 0, 1, 1, 0, 0, 0, 0));
    restart();
    pulse(4); set_a(1'b1);
    pulse(3);
    check_cnt("R5 frozen after B-capture", 4);
    rd(A_STAT, v); check("R5 freeze keeps clock enabled", v & 32'h100, 32'h100);
    wr(A_CMD, 32'h4); pulse(1);
    check_cnt("R5 trigger releases freeze", 0);
    pulse(2);
    check_cnt("R5 counting resumed", 2);
    set_a(1'b0);

    // clock-off on B-capture
    wr(A_MODE, mk_mode(5, 0, 0, 0, 1, 0, 1, 0, 0, 0));
    restart();
    pulse(3); set_a(1'b1);
    rd(A_CAPB, v); check("R5 B-capture value", v, 32'd3);
    rd(A_STAT, v); check("R5 clock disabled", v & 32'h100, 32'h0);
    pulse(2);
    check_cnt("R5 holds while disabled", 3);
    wr(A_CMD, 32'h1); pulse(2);
    check_cnt("R5 re-enabled", 5);
    set_a(1'b0);

    // external trigger
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 1, 1, 0));
    restart();
    pulse(6);
    rd(A_STAT, v);
    in_b = 1'b1; cyc(5);
    rd(A_STAT, v); check("R7 trigger flag", v & 32'h20, 32'h20);
    pulse(1);
    check_cnt("R7 restart from B", 0);
    in_b = 1'b0; cyc(5);
    pulse(2);
    check_cnt("R7 falling B ignored", 2);
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 2, 0, 0));
    set_a(1'b1); pulse(1);
    check_cnt("R7 rising A ignored", 3);
    set_a(1'b0); pulse(1);
    check_cnt("R7 falling A restarts", 0);

    // compare
    wr(A_RCMP, 32'd5);
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    restart();
    pulse(8);
    check_cnt("R8 compare restart", 2);
    rd(A_STAT, v); check("R8 compare flag", v & 32'h4, 32'h4);
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    restart();
    pulse(8);
    check_cnt("R8 no restart when off", 8);

    // overrun
    wr(A_MODE, mk_mode(5, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    rd(A_CAPA, v); rd(A_STAT, v);
    set_a(1'b1); set_a(1'b0); set_a(1'b1);
    rd(A_STAT, v); check("R9 overrun raised", v & 32'h2, 32'h2);
    set_a(1'b0);
    rd(A_CAPA, v); rd(A_STAT, v);
    set_a(1'b1); rd(A_CAPA, v); set_a(1'b0); set_a(1'b1);
    rd(A_STAT, v); check("R9 read prevents overrun", v & 32'hA, 32'h8);
    set_a(1'b0);

    // overflow
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    restart();
    pulse((1 << CNT_W) - 1);
    check_cnt("R11 all ones", (1 << CNT_W) - 1);
    rd(A_STAT, v); check("R11 no flag before wrap", v & 32'h1, 32'h0);
    pulse(1);
    check_cnt("R11 wraps", 0);
    rd(A_STAT, v); check("R11 overflow flag", v & 32'h1, 32'h1);

    // start and halt together
    wr(A_CMD, 32'h3);
    rd(A_STAT, v); check("R10 halt wins", v & 32'h100, 32'h0);
    pulse(2);
    check_cnt("R10 hold after both", 0);
    wr(A_CMD, 32'h1);

    // interrupt mask
    wr(A_MODE, mk_mode(5, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    rd(A_STAT, v);
    wr(A_IEN, 32'h8);
    rd(A_IMASK, v); check("R12 mask set", v, 32'h8);
    check("R12 irq idle", 32'(irq), 32'h0);
    set_a(1'b1);
    check("R12 irq on masked flag", 32'(irq), 32'h1);
    rd(A_STAT, v); check("R12 flag reported", v & 32'h8, 32'h8);
    check("R12 irq after clear-on-read", 32'(irq), 32'h0);
    wr(A_IEN, 32'h1); wr(A_IDIS, 32'h8);
    rd(A_IMASK, v); check("R12 mask clear only written bits", v, 32'h1);
    set_a(1'b0); set_a(1'b1);
    check("R12 irq masked off", 32'(irq), 32'h0);
    set_a(1'b0);
    wr(A_IDIS, 32'h3F);

    // random capture sequences
    begin
      int k1, k2, k3;
      void'($urandom(32'd2024));
      wr(A_MODE, mk_mode(5, 0, 0, 1, 2, 0, 0, 0, 0, 0));
      for (int it = 0; it < 20; it++) begin
        k1 = int'($urandom % 30) + 1;
        k2 = int'($urandom % 30) + 1;
        k3 = int'($urandom % 10);
        restart();
        pulse(k1); set_a(1'b1); pulse(k2); set_a(1'b0); pulse(k3);
        rd(A_CAPA, v); check("R4 random A-capture", v, wrap(k1));
        rd(A_CAPB, v); check("R4 random B-capture", v, wrap(k1 + k2));
        check_cnt("R1 random count", k1 + k2 + k3);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule